// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for a four-beat burst. A load strobe captures an external address. The upper bits are then held fixed for the whole burst. The two lowest bits are the starting beat of the burst. Each later cycle with the advance strobe set moves the burst on by one beat. After four beats the sequence returns to the starting beat.

The order of the beats is chosen by a static mode input. In linear order the low bits count upward modulo four from the start. In interleaved order the low bits are the start XOR a beat count. The block keeps the start and the beat count as separate registers and forms the output low bits from them combinationally. A hold input freezes all state, so load and advance have no effect while hold is high. Reset is synchronous and active low.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low at a rising edge, the state clears, whatever load or advance do, so addr_o reads all zeros after reset.
- R2: A cycle with load_i high and hold_i low captures addr_i. From the next cycle addr_o equals that addr_i in both orders, because the beat count is zero.
- R3: With ilv_mode_i = 0 (linear), after k advances since the load the low two bits of addr_o equal (start + k) mod 4. Starting at 01 the beats are 01, 10, 11, 00.
- R4: With ilv_mode_i = 1 (interleaved), after k advances the low two bits equal start XOR (k mod 4). Starting at 01 the beats are 01, 00, 11, 10. Starting at 10 they are 10, 11, 00, 01.
- R5: After the fourth advance the low bits return to the starting value, and the sequence repeats.
- R6: While hold_i is high, addr_o does not change, and load_i, adv_i and addr_i have no effect.
- R7: When load_i and adv_i are both high, the load wins and the beat count restarts at zero.
- R8: Between loads, the bits of addr_o above the two lowest bits stay equal to the loaded upper bits.
- R9: A cycle with hold_i low, load_i low and adv_i low leaves addr_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_i | input | 1 | High freezes the sequencer |
| load_i | input | 1 | Capture addr_i and start a burst |
| adv_i | input | 1 | Step to the next beat |
| ilv_mode_i | input | 1 | 0 selects linear order, 1 selects interleaved order |
| addr_i | input | ADDR_W | External starting address |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The bench builds the block with ADDR_W = 6 and the beat field at its default width of 2. With these values the bench sweeps all 64 starting addresses in both orders. For each start it walks five advances, so every start/beat pair is checked and so is the wrap back to the start. Directed passes then cover hold, idle cycles, a load in the same cycle as an advance, a change of mode during a burst, and a load asserted during reset.

// File: rtl/bseq_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: a single-bit mode input, where 0 selects linear order and 1 selects interleaved order.
package bseq_pkg;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } act_e;

endpackage

// File: rtl/bseq_launch_reg.sv
// Module: holds the address captured by a load.
// The upper bits stay fixed for the burst, and the low BEAT_W bits are the start beat.
// Assumes: the action is already resolved by the top (hold and load priority are applied there).
module bseq_launch_reg #(
    parameter int ADDR_W = 8,
    parameter int BEAT_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bseq_pkg::act_e      act_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [ADDR_W-1:0]   base_o
);
    import bseq_pkg::*;

    logic [ADDR_W-1:0] base_q;

    // Capture the external address on a load; otherwise keep the value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (act_i == ACT_LOAD) begin
            base_q <= addr_i;
        end
    end

    assign base_o = base_q;

    // R8: the captured address changes only through a load.
    p_base_only_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i != ACT_LOAD) |=> $stable(base_q));

    // R2: a load captures the address that was presented with it.
    p_base_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_LOAD) |=> (base_q == $past(addr_i)));

endmodule

// File: rtl/bseq_beat_ctr.sv
// Module: beat counter for the burst.
// A load clears the count, and a step adds one modulo 2**BEAT_W. Because the count wraps, the
// sequence returns to the start beat after 2**BEAT_W steps.
// Assumes: the action is resolved upstream.
module bseq_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bseq_pkg::act_e      act_i,
    output logic [BEAT_W-1:0]   count_o
);
    import bseq_pkg::*;

    localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

    logic [BEAT_W-1:0] count_q;

    // Clear the count on a load, add one on a step, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            unique case (act_i)
                ACT_LOAD: count_q <= '0;
                ACT_STEP: count_q <= count_q + ONE;
                default:  count_q <= count_q;
            endcase
        end
    end

    assign count_o = count_q;

    // R7: a load always restarts the count at zero.
    p_load_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_LOAD) |=> (count_q == '0));

    // R5: a step moves the count by exactly one, with wrap.
    p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_STEP) |=> (count_q == BEAT_W'($past(count_q) + ONE)));

    // R9: with no action the count stays where it is.
    p_idle_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_NONE) |=> $stable(count_q));

endmodule

// File: rtl/bseq_order_map.sv
// Module: maps the start beat and the beat count to the output low bits.
// In linear order the output is start + count with wrap. In interleaved order it is start XOR count.
// Assumes: purely combinational; mode may change at any time.
module bseq_order_map #(
    parameter int BEAT_W = 2
) (
    input  bseq_pkg::order_e    order_i,
    input  logic [BEAT_W-1:0]   start_i,
    input  logic [BEAT_W-1:0]   count_i,
    output logic [BEAT_W-1:0]   beat_o
);
    import bseq_pkg::*;

    logic [BEAT_W-1:0] lin_beat;
    logic [BEAT_W-1:0] ilv_beat;
    logic [BEAT_W:0]   carry;

    // Ripple adder for linear order; the carry out of the top bit is dropped, which gives the wrap.
    assign carry[0] = 1'b0;
    for (genvar b = 0; b < BEAT_W; b++) begin : g_lin
        assign lin_beat[b]  = start_i[b] ^ count_i[b] ^ carry[b];
        assign carry[b+1]   = (start_i[b] & count_i[b]) | (carry[b] & (start_i[b] ^ count_i[b]));
    end

    // Bitwise XOR for interleaved order.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_beat[b] = start_i[b] ^ count_i[b];
    end

    // Pick the order selected by the mode.
    always_comb begin
        beat_o = (order_i == ORDER_INTERLEAVE) ? ilv_beat : lin_beat;
    end

    // R5: at count zero both orders give the start beat.
    always_comb begin
        if (count_i == '0) begin
            a_zero_is_start_r5: assert (beat_o == start_i);
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Module: top of the burst address sequencer.
// It works out the action for the cycle: hold beats load, and load beats advance. The action then
// drives the address register and the beat counter, and the low output bits are formed from them.
// Assumes: ilv_mode_i is static during normal use; if it changes, the output follows at once.
module burst_addr_seq #(
    parameter int ADDR_W = 8,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic              ilv_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    import bseq_pkg::*;

    localparam int UP_W = ADDR_W - BEAT_W;

    act_e              act;
    order_e            order;
    logic [ADDR_W-1:0] base;
    logic [BEAT_W-1:0] count;
    logic [BEAT_W-1:0] beat;

    // Resolve the action for this cycle: hold first, then load, then advance.
    always_comb begin
        if (hold_i)      act = ACT_NONE;
        else if (load_i) act = ACT_LOAD;
        else if (adv_i)  act = ACT_STEP;
        else             act = ACT_NONE;
    end

    assign order = order_e'(ilv_mode_i);

    bseq_launch_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_launch (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act),
        .addr_i (addr_i),
        .base_o (base)
    );

    bseq_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (act),
        .count_o (count)
    );

    bseq_order_map #(.BEAT_W(BEAT_W)) u_map (
        .order_i (order),
        .start_i (base[BEAT_W-1:0]),
        .count_i (count),
        .beat_o  (beat)
    );

    // Put the fixed upper bits and the sequenced low bits together.
    always_comb begin
        addr_o = {base[ADDR_W-1:BEAT_W], beat};
    end

    // R6: hold freezes the address when the mode is steady.
    p_hold_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && $stable(ilv_mode_i)) |=> $stable(addr_o));

    // R8: the upper bits change only when a load is accepted.
    p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i || !load_i) |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

    // R2: an accepted load shows the loaded address on the next cycle.
    p_load_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && load_i) |=> (addr_o == $past(addr_i)));

    // R1: reset clears the output.
    p_reset_clear_r1: assert property (@(posedge clk)
        (!rst_n) |=> (addr_o == '0));

    // Check the parameters when the block is built.
    initial begin
        a_widths_ok: assert (BEAT_W >= 1 && UP_W >= 1);
    end

endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

    localparam int AW = 6;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hold_i = 1'b0;
    logic          load_i = 1'b0;
    logic          adv_i = 1'b0;
    logic          ilv_mode_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;

    int errors = 0;
    int checks = 0;

    // reference model state
    int m_upper = 0;
    int m_start = 0;
    int m_cnt = 0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .load_i(load_i),
        .adv_i(adv_i), .ilv_mode_i(ilv_mode_i), .addr_i(addr_i), .addr_o(addr_o)
    );

    function automatic int exp_addr();
        int lo;
        if (ilv_mode_i) lo = m_start ^ m_cnt;
        else            lo = (m_start + m_cnt) % 4;
        return m_upper * 4 + lo;
    endfunction

    task automatic check(input string tag, input int exp);
        checks++;
        if (int'(addr_o) != exp) begin
            errors++;
            $display("FAIL %s: addr_o=%0d expected=%0d", tag, addr_o, exp);
        end
    endtask

    // drive one cycle at the falling edge, update the model at the rising edge, check 1 ns later
    task automatic step(input logic h, input logic l, input logic a, input int ad, input string tag);
        @(negedge clk);
        hold_i = h; load_i = l; adv_i = a; addr_i = AW'(ad);
        @(posedge clk);
        if (!h) begin
            if (l) begin
                m_upper = ad / 4; m_start = ad % 4; m_cnt = 0;
            end else if (a) begin
                m_cnt = (m_cnt + 1) % 4;
            end
        end
        #1;
        check(tag, exp_addr());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: a load during reset is ignored and the output is zero
        rst_n = 1'b0; load_i = 1'b1; addr_i = 6'h2d;
        repeat (3) @(posedge clk);
        #1; check("R1 reset", 0);
        @(negedge clk); rst_n = 1'b1; load_i = 1'b0;
        @(posedge clk); #1; check("R1 after reset", 0);

        // R2 R3 R4 R5: every start address in both orders, five advances
        for (int md = 0; md < 2; md++) begin
            ilv_mode_i = md[0];
            for (int ad = 0; ad < 64; ad++) begin
                step(1'b0, 1'b1, 1'b0, ad, "R2 load");
                for (int k = 1; k <= 5; k++) begin
                    step(1'b0, 1'b0, 1'b1, 0, md ? "R4 interleaved beat" : "R3 linear beat");
                    if (k == 4) check("R5 wrap to start", ad);
                    check("R8 upper fixed", (ad / 4) * 4 + (addr_o % 4));
                end
            end
        end

        // R3: the linear order from 01 is 01 10 11 00
        ilv_mode_i = 1'b0;
        step(1'b0, 1'b1, 1'b0, 6'h21, "R3 load");
        step(1'b0, 1'b0, 1'b1, 0, "R3 seq"); check("R3 literal 10", 6'h22);
        step(1'b0, 1'b0, 1'b1, 0, "R3 seq"); check("R3 literal 11", 6'h23);
        step(1'b0, 1'b0, 1'b1, 0, "R3 seq"); check("R3 literal 00", 6'h20);

        // R4: the interleaved order from 10 is 10 11 00 01
        ilv_mode_i = 1'b1;
        step(1'b0, 1'b1, 1'b0, 6'h16, "R4 load");
        step(1'b0, 1'b0, 1'b1, 0, "R4 seq"); check("R4 literal 11", 6'h17);
        step(1'b0, 1'b0, 1'b1, 0, "R4 seq"); check("R4 literal 00", 6'h14);
        step(1'b0, 1'b0, 1'b1, 0, "R4 seq"); check("R4 literal 01", 6'h15);

        // R6: while held, load and advance have no effect
        for (int i = 0; i < 4; i++) begin
            step(1'b1, i[0], 1'b1, 6'h3f - i, "R6 hold");
            check("R6 hold value", 6'h15);
        end

        // R9: an idle cycle keeps the address
        step(1'b0, 1'b0, 1'b0, 6'h3f, "R9 idle");
        check("R9 idle value", 6'h15);

        // R7: load and advance together; the load wins and the count restarts
        step(1'b0, 1'b0, 1'b1, 0, "R7 pre");
        step(1'b0, 1'b1, 1'b1, 6'h0b, "R7 load wins");
        check("R7 at start", 6'h0b);
        step(1'b0, 1'b0, 1'b1, 0, "R7 first step"); check("R7 count from zero", 6'h0a);

        // R3 R4: changing the mode mid-burst is reflected at once
        @(negedge clk); ilv_mode_i = 1'b0; hold_i = 1'b0; load_i = 1'b0; adv_i = 1'b0;
        #1; check("R3 mode switch", exp_addr());

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule